// File: doc/BRIEF.md
# Bus Ownership Request Controller

This block sits on the master side of a shared, arbitrated system bus in the AHB style. It decides when the master raises its bus request and its lock signal. It tracks whether the master owns the address phase. It tells the master's transfer engine in which cycles a non-IDLE beat may be placed on the bus. The engine starts a job, which is one single transfer or one burst, optionally locked, by pulsing `job_start` with the burst code and the lock flag. The controller then requests the bus, opens an issue window whenever ownership is held, and counts accepted beats until the job ends.

How long the request is held depends on the burst kind. An undefined-length incrementing burst keeps its request up until its final beat has been accepted. A fixed-length burst lets the request go once its first beat is on the bus, and it raises the request again whenever ownership is lost mid-burst. A locked job raises the lock a configurable number of cycles before its first address phase. The lock stays high across every beat and drops right after the last address phase. A RETRY or SPLIT response restarts the request. The engine remains responsible for reissuing any beat.

Top module: `bus_req_ctl`

## Requirements
- R1: `addr_own` takes the value of `hgrant` at each clock edge where `hready` is high and holds its value across edges where `hready` is low. It resets to the `DEFAULT_OWNER` parameter.
- R2: Burst codes on `job_burst` are 0 single, 1 undefined-length incrementing, 2/3 wrapping/incrementing of 4 beats, 4/5 of 8 beats, and 6/7 of 16 beats. `issue` is high while a job is running and `addr_own` is high. `beat_acc` is `issue` qualified by `hready`. A fixed-length job ends, with `busy` dropping, right after its beat count of accepted beats, and a single ends after one beat.
- R3: For an undefined-length burst (code 1), `hbusreq` stays high for the whole job. The job ends after the beat accepted while `incr_last` is high.
- R4: For an unlocked fixed-length burst, `hbusreq` is low from the cycle after the first accepted beat for as long as `addr_own` stays high.
- R5: During a job, `hbusreq` is high in every cycle in which `addr_own` is low.
- R6: A locked job raises `hlock` in the cycle after `job_start`. `hlock` then stays high for exactly `LOCK_LEAD` cycles with `issue` low before the first issue window opens.
- R7: During a locked job, `hlock` and `hbusreq` stay high until the last beat is accepted. Both are low in the following cycle.
- R8: When a job starts while `addr_own` is already high, `issue` and `hbusreq` are both high in the first cycle after `job_start`, with no earlier request cycle.
- R9: A response code of 2 (RETRY) or 3 (SPLIT) on `hresp` during a job makes `hbusreq` high from the next cycle.
- R10: `job_start` while `busy` is high is ignored: the running job keeps its burst kind and beat count.
- R11: After reset, `hbusreq`, `hlock`, `issue`, `beat_acc` and `busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| job_start | input | 1 | Start a job (taken only when idle) |
| job_burst | input | 3 | Burst code of the job |
| job_lock | input | 1 | Job is a locked sequence |
| incr_last | input | 1 | Beat now offered is the last of an undefined-length burst |
| hgrant | input | 1 | Grant from the arbiter |
| hready | input | 1 | Bus ready |
| hresp | input | 2 | Slave response code |
| hbusreq | output | 1 | Bus request to the arbiter |
| hlock | output | 1 | Lock request to the arbiter |
| addr_own | output | 1 | Master owns the address phase |
| issue | output | 1 | A non-IDLE beat may be driven this cycle |
| beat_acc | output | 1 | The beat driven this cycle is accepted |
| busy | output | 1 | A job is in progress |

## Verification
Directed jobs separate the request-release policies. A four-beat burst with a steady grant shows the early release after the first beat. The same burst with the grant withdrawn shows the re-request. An undefined-length burst shows the request held to the end, and a locked wrapping burst shows the lock lead and hold. Grant changes during low `hready`, a job started on a grant that is already held, a RETRY in mid-burst and a start pulse during a running job each isolate one of the remaining rules. A long stretch of random grant, ready, response and job traffic is then followed against a behavioural model every cycle, which exercises the interleavings the directed cases miss.

// File: rtl/breq_pkg.sv
package breq_pkg;

   typedef enum logic [2:0] {
      BT_SINGLE = 3'd0,
      BT_INCR   = 3'd1,
      BT_WRAP4  = 3'd2,
      BT_INCR4  = 3'd3,
      BT_WRAP8  = 3'd4,
      BT_INCR8  = 3'd5,
      BT_WRAP16 = 3'd6,
      BT_INCR16 = 3'd7
   } burst_e;

   typedef enum logic [1:0] {
      RQ_IDLE = 2'd0,
      RQ_LEAD = 2'd1,
      RQ_RUN  = 2'd2
   } rq_state_e;

   localparam logic [1:0] RSP_RETRY = 2'd2;
   localparam logic [1:0] RSP_SPLIT = 2'd3;
   localparam int unsigned LONGEST_BURST = 16;

   function automatic logic is_fixed(input logic [2:0] code);
      return code >= 3'd2;
   endfunction

   // beats of a fixed-length code; 1 for the two other codes
   function automatic int unsigned fixed_beats(input logic [2:0] code);
      if (code < 3'd2) return 1;
      return 4 << ((int'(code) - 2) / 2);
   endfunction

endpackage

// File: rtl/breq_beat_ctr.sv
module breq_beat_ctr #(
   parameter int unsigned MAX_BEATS = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load,
   input  logic [2:0] load_code,
   input  logic       dec,
   output logic       last
);
   import breq_pkg::*;

   localparam int unsigned CNT_W = $clog2(MAX_BEATS + 1);

   logic [CNT_W-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         left_q <= '0;
      else if (load)
         left_q <= CNT_W'(fixed_beats(load_code));
      else if (dec && left_q != '0)
         left_q <= left_q - 1'b1;
   end

   assign last = (left_q == CNT_W'(1));

endmodule

// File: rtl/breq_lock_seq.sv
module breq_lock_seq #(
   parameter int unsigned LOCK_LEAD = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic release_lk,
   output logic lock_o,
   output logic lead_done
);
   localparam int unsigned LEAD_W = $clog2(LOCK_LEAD + 1);

   logic [LEAD_W-1:0] lead_q;
   logic              lock_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lead_q <= '0;
         lock_q <= 1'b0;
      end else begin
         if (arm)
            lead_q <= LEAD_W'(LOCK_LEAD);
         else if (lead_q != '0)
            lead_q <= lead_q - 1'b1;

         if (arm)
            lock_q <= 1'b1;
         else if (release_lk)
            lock_q <= 1'b0;
      end
   end

   assign lock_o    = lock_q;
   assign lead_done = (lead_q == LEAD_W'(1));

endmodule

// File: rtl/bus_req_ctl.sv
module bus_req_ctl
   import breq_pkg::*;
#(
   parameter int unsigned MAX_BEATS      = 16,
   parameter int unsigned LOCK_LEAD      = 1,
   parameter bit          DEFAULT_OWNER  = 1'b0,
   parameter bit          REQ_HOLD_FIXED = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       job_start,
   input  logic [2:0] job_burst,
   input  logic       job_lock,
   input  logic       incr_last,
   input  logic       hgrant,
   input  logic       hready,
   input  logic [1:0] hresp,
   output logic       hbusreq,
   output logic       hlock,
   output logic       addr_own,
   output logic       issue,
   output logic       beat_acc,
   output logic       busy
);

   generate
      if (MAX_BEATS < LONGEST_BURST) begin : g_bad_beats
         $error("MAX_BEATS must cover a 16-beat burst");
      end
      if (LOCK_LEAD < 1) begin : g_bad_lead
         $error("LOCK_LEAD must be at least one cycle");
      end
   endgenerate

   rq_state_e  st_q, st_d;
   logic       own_q;
   logic       hold_q;
   logic [2:0] burst_q;
   logic       lock_q;
   logic       start_acc, go, fixed_q, ctr_last, lead_done;
   logic       last_beat, rsp_restart, rel_ok, lock_out;

   assign start_acc   = (st_q == RQ_IDLE) && job_start;
   assign go          = (st_q == RQ_RUN) && own_q && hready;
   assign fixed_q     = is_fixed(burst_q);
   assign last_beat   = go && (fixed_q ? ctr_last
                                       : ((burst_q == BT_SINGLE) || incr_last));
   assign rsp_restart = (st_q != RQ_IDLE) &&
                        ((hresp == RSP_RETRY) || (hresp == RSP_SPLIT));

   // request release policy for fixed-length bursts
   generate
      if (REQ_HOLD_FIXED) begin : g_hold_all
         assign rel_ok = 1'b0;
      end else begin : g_release_early
         assign rel_ok = fixed_q && !lock_q;
      end
   endgenerate

   // ownership follows grant only on ready edges
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         own_q <= DEFAULT_OWNER;
      else if (hready)
         own_q <= hgrant;
   end

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         RQ_IDLE: if (job_start) st_d = job_lock ? RQ_LEAD : RQ_RUN;
         RQ_LEAD: if (lead_done) st_d = RQ_RUN;
         RQ_RUN:  if (last_beat) st_d = RQ_IDLE;
         default: st_d = RQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= RQ_IDLE;
         burst_q <= BT_SINGLE;
         lock_q  <= 1'b0;
      end else begin
         st_q <= st_d;
         if (start_acc) begin
            burst_q <= job_burst;
            lock_q  <= job_lock;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         hold_q <= 1'b0;
      else if (start_acc || rsp_restart)
         hold_q <= 1'b1;
      else if (last_beat || (go && rel_ok))
         hold_q <= 1'b0;
   end

   breq_beat_ctr #(.MAX_BEATS(MAX_BEATS)) u_ctr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (start_acc),
      .load_code (job_burst),
      .dec       (go),
      .last      (ctr_last)
   );

   breq_lock_seq #(.LOCK_LEAD(LOCK_LEAD)) u_lock (
      .clk        (clk),
      .rst_n      (rst_n),
      .arm        (start_acc && job_lock),
      .release_lk (last_beat),
      .lock_o     (lock_out),
      .lead_done  (lead_done)
   );

   assign busy     = (st_q != RQ_IDLE);
   assign hbusreq  = busy && (hold_q || !own_q);
   assign hlock    = lock_out;
   assign addr_own = own_q;
   assign issue    = (st_q == RQ_RUN) && own_q;
   assign beat_acc = go;

endmodule

// File: rtl/breq_chk.sv
module breq_chk #(
   parameter int unsigned LOCK_LEAD = 1
) (
   input logic       clk,
   input logic       rst_n,
   input logic       hready,
   input logic [1:0] hresp,
   input logic       hbusreq,
   input logic       hlock,
   input logic       addr_own,
   input logic       issue,
   input logic       beat_acc,
   input logic       busy
);

   a_r1_own_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      !hready |=> $stable(addr_own));

   a_r5_rerequest: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !addr_own) |-> hbusreq);

   a_r6_lock_before_issue: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hlock) |-> !issue);

   a_r7_lock_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (hlock && !beat_acc) |=> hlock);

   a_r7_lock_requests: assert property (@(posedge clk) disable iff (!rst_n)
      hlock |-> hbusreq);

   a_r7_lock_gone_at_end: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> !hlock);

   a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && (hresp == 2'd2 || hresp == 2'd3)) |=> (!busy || hbusreq));

   a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!hlock && !hbusreq && !issue && !beat_acc));

endmodule

bind bus_req_ctl breq_chk #(.LOCK_LEAD(LOCK_LEAD)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .hready   (hready),
   .hresp    (hresp),
   .hbusreq  (hbusreq),
   .hlock    (hlock),
   .addr_own (addr_own),
   .issue    (issue),
   .beat_acc (beat_acc),
   .busy     (busy)
);

// File: tb/sim_bus_req_ctl.sv
`timescale 1ns/1ps
module sim_bus_req_ctl;

   localparam int LP = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       job_start = 1'b0;
   logic [2:0] job_burst = 3'd0;
   logic       job_lock = 1'b0;
   logic       incr_last = 1'b0;
   logic       hgrant = 1'b0;
   logic       hready = 1'b1;
   logic [1:0] hresp = 2'd0;
   logic       hbusreq, hlock, addr_own, issue, beat_acc, busy;

   int n_chk = 0;
   int n_bad = 0;
   bit cmp_on = 1'b0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   bus_req_ctl #(.LOCK_LEAD(LP)) u0 (
      .clk(clk), .rst_n(rst_n), .job_start(job_start), .job_burst(job_burst),
      .job_lock(job_lock), .incr_last(incr_last), .hgrant(hgrant),
      .hready(hready), .hresp(hresp), .hbusreq(hbusreq), .hlock(hlock),
      .addr_own(addr_own), .issue(issue), .beat_acc(beat_acc), .busy(busy)
   );

   // behavioural reference
   int m_st = 0;          // 0 idle, 1 lock lead, 2 running
   int m_left = 0;
   int m_lead = 0;
   bit m_own = 1'b0;
   bit m_hold = 1'b0;
   bit m_lk = 1'b0;
   bit m_lkjob = 1'b0;
   int m_code = 0;

   function automatic int beats_for(int code);
      case (code)
         2, 3:    return 4;
         4, 5:    return 8;
         6, 7:    return 16;
         default: return 1;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_st = 0; m_left = 0; m_lead = 0; m_own = 1'b0;
         m_hold = 1'b0; m_lk = 1'b0; m_lkjob = 1'b0; m_code = 0;
      end else begin
         automatic bit nxt_own = hready ? hgrant : m_own;
         automatic bit acc = (m_st == 2) && m_own && hready;
         automatic bit was_busy = (m_st != 0);
         automatic bit fin;
         if (m_st == 0) begin
            if (job_start) begin
               m_code = int'(job_burst); m_lkjob = job_lock; m_hold = 1'b1;
               m_left = beats_for(m_code);
               if (job_lock) begin m_lk = 1'b1; m_lead = LP; m_st = 1; end
               else m_st = 2;
            end
         end else if (m_st == 1) begin
            m_lead--;
            if (m_lead == 0) m_st = 2;
         end else if (acc) begin
            fin = (m_code >= 2) ? (m_left == 1) : ((m_code == 0) || incr_last);
            m_left--;
            if (fin) begin m_st = 0; m_lk = 1'b0; m_hold = 1'b0; end
            else if (m_code >= 2 && !m_lkjob) m_hold = 1'b0;
         end
         if (was_busy && (hresp == 2'd2 || hresp == 2'd3)) m_hold = 1'b1;
         m_own = nxt_own;
      end
   end

   task automatic chk(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && cmp_on) begin
         automatic bit e_busy = (m_st != 0);
         automatic bit e_issue = (m_st == 2) && m_own;
         chk("R1 addr_own", int'(addr_own), int'(m_own));
         chk("R2 R8 issue", int'(issue), int'(e_issue));
         chk("R2 beat_acc", int'(beat_acc), int'(e_issue && hready));
         chk("R2 R3 R10 busy", int'(busy), int'(e_busy));
         chk("R3 R4 R5 R9 hbusreq", int'(hbusreq), int'(e_busy && (m_hold || !m_own)));
         chk("R6 R7 hlock", int'(hlock), int'(m_lk));
      end
   end

   task automatic step();
      @(negedge clk);
      #1;
   endtask

   task automatic start_job(int code, bit lk);
      job_burst = 3'(code); job_lock = lk; job_start = 1'b1;
      step();
      job_start = 1'b0; job_lock = 1'b0;
   endtask

   // run until idle, returning accepted beats
   task automatic finish_job(output int beats);
      beats = 0;
      for (int g = 0; g < 200 && busy; g++) begin
         if (beat_acc) beats++;
         step();
      end
   endtask

   initial begin : watchdog
      #(200000 * 4);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin : stim
      int nb;
      int cnt;
      step(); step();
      // R11: reset state
      chk("R11 hbusreq", int'(hbusreq), 0);
      chk("R11 hlock", int'(hlock), 0);
      chk("R11 busy", int'(busy), 0);
      chk("R11 issue", int'(issue | beat_acc), 0);
      chk("R1 reset owner", int'(addr_own), 0);
      rst_n = 1'b1;
      cmp_on = 1'b1;
      step();

      // R2: single, grant arrives late
      start_job(0, 1'b0);
      chk("R2 waits for grant", int'(issue), 0);
      chk("R5 request while not owning", int'(hbusreq), 1);
      step(); hgrant = 1'b1; step();
      finish_job(nb);
      chk("R2 single beats", nb, 1);

      // R4, R5: four-beat burst, early release then re-request
      start_job(3, 1'b0);
      chk("R8 issue at once", int'(issue), 1);
      chk("R8 request with issue", int'(hbusreq), 1);
      step();
      chk("R4 request released", int'(hbusreq), 0);
      nb = 1;
      hgrant = 1'b0;
      if (beat_acc) nb++;
      step();
      chk("R5 request after grant loss", int'(hbusreq), 1);
      step(); step();
      hgrant = 1'b1;
      step();
      finish_job(cnt);
      chk("R2 four beats total", nb + cnt, 4);

      // R1: ownership frozen while ready is low
      hready = 1'b0; hgrant = 1'b0;
      step();
      chk("R1 held while not ready", int'(addr_own), 1);
      hready = 1'b1;
      step();
      chk("R1 follows grant when ready", int'(addr_own), 0);
      hgrant = 1'b1;
      step();

      // R3: undefined-length burst of five beats
      start_job(1, 1'b0);
      cnt = 0;
      for (int g = 0; g < 100 && busy; g++) begin
         chk("R3 request held", int'(hbusreq), 1);
         incr_last = (cnt == 4);
         if (beat_acc) cnt++;
         step();
      end
      incr_last = 1'b0;
      chk("R3 five beats", cnt, 5);

      // R6, R7: locked eight-beat wrap
      start_job(4, 1'b1);
      cnt = 0;
      for (int g = 0; g < 20 && !issue; g++) begin
         if (hlock) cnt++;
         step();
      end
      chk("R6 lock lead cycles", cnt, LP);
      nb = 0;
      for (int g = 0; g < 100 && busy; g++) begin
         chk("R7 lock through burst", int'(hlock), 1);
         chk("R7 request through lock", int'(hbusreq), 1);
         if (beat_acc) nb++;
         step();
      end
      chk("R7 lock dropped", int'(hlock), 0);
      chk("R2 eight locked beats", nb, 8);

      // R9, R10: retry restarts request; start while busy ignored
      start_job(5, 1'b0);
      step();
      chk("R4 released before retry", int'(hbusreq), 0);
      hresp = 2'd2;
      step();
      hresp = 2'd0;
      chk("R9 request after retry", int'(hbusreq), 1);
      job_burst = 3'd0; job_start = 1'b1;
      step();
      job_start = 1'b0;
      finish_job(cnt);
      chk("R10 burst kept its length", cnt + 3, 8);
      chk("R10 idle after burst", int'(busy), 0);

      // random traffic against the reference
      for (int i = 0; i < 3000; i++) begin
         hgrant    = ($urandom_range(0, 3) != 0);
         hready    = ($urandom_range(0, 4) != 0);
         hresp     = ($urandom_range(0, 15) == 0) ? 2'($urandom_range(1, 3)) : 2'd0;
         job_start = ($urandom_range(0, 4) == 0);
         job_burst = 3'($urandom_range(0, 7));
         job_lock  = ($urandom_range(0, 3) == 0);
         incr_last = ($urandom_range(0, 3) == 0);
         step();
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule